// File: doc/BRIEF.md
# Stepped Transmit Level Control Sequencer

This block is the digital core of a transmit amplitude loop. It holds a 5-bit attenuation code that selects one of 32 steps, code 0 being 0 dB and code 31 the deepest cut of about -26 dB, with roughly 0.84 dB between neighbouring codes. Two comparator flags come from an analog peak detector that watches the feedback signal. `peak_ge_low` is high while the signal is at or above the lower threshold. `peak_gt_high` is high while it is strictly above the upper threshold.

Time is cut into fixed update periods. With the default parameters and an 11.0592 MHz clock, each period is 1536 cycles (7200 Hz). It holds 384 settling cycles, during which the attenuator is left to settle and the flags are ignored. These are followed by 1152 detect cycles, during which each flag is latched sticky. The step is decided on the last detect cycle:
- If the upper flag was seen, attenuation goes up one code.
- If neither flag was seen, attenuation goes down one code, so the gain rises.
- Otherwise the code holds.

The sequencer is a two-state machine with a cycle counter. SETTLE is entered from reset. SETTLE moves to DETECT when the settle count expires. DETECT returns to SETTLE when the detect count expires, and the step is committed on that transition. The `win_detect` output tells the analog side which window is open.

Top module: `alc_level_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `atten_code` is 31 (maximum attenuation) and `win_detect` is 0.
- R2: After reset, `win_detect` is low for SETTLE_CYC cycles, then high for DETECT_CYC cycles, and this repeats without gaps. The defaults of 384 and 1152 give a 1536-cycle (7200 Hz) period at 11.0592 MHz.
- R3: `atten_code` changes only on the clock edge that ends a detect window; on every other edge it is stable.
- R4: If neither flag was high on any detect cycle of a window, the code decreases by exactly one at the window end (gain up one step).
- R5: If `peak_ge_low` was high on at least one detect cycle and `peak_gt_high` on none, the code is unchanged at the window end.
- R6: If `peak_gt_high` was high on at least one detect cycle, the code increases by exactly one at the window end, whatever `peak_ge_low` did.
- R7: Flag values during settle cycles have no effect. Flags seen in one detect window do not carry into the next window.
- R8: The code saturates: a decrease at 0 leaves 0, an increase at 31 leaves 31.
- R9: A flag that is high for a single detect cycle, including the first or the last one, counts for the whole window.
- R10: From code 31 with no flags, the code reaches 0 after exactly 31 windows. With the defaults this is 47,616 cycles, under 5 ms.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, 11.0592 MHz nominal |
| rst_n | input | 1 | Asynchronous active-low reset |
| peak_ge_low | input | 1 | Feedback at or above the lower threshold |
| peak_gt_high | input | 1 | Feedback above the upper threshold |
| atten_code | output | 5 | Attenuation step, 0 = 0 dB, 31 = deepest |
| win_detect | output | 1 | High during the detect window, low during settling |

## Verification
The hardest cases to reach are single-cycle flag pulses that land exactly on the first or last detect cycle. A flag raised in one window must also be shown not to leak into the next, and flags raised only while settling must be shown to have no effect. The bench keeps its own phase count, so it can place pulses on chosen cycles of the window. It also drives the upper flag throughout settling, then opens a detect window with only the lower flag. Directed runs walk the code across its full range to both rails. Random windows then mix all three outcomes against a cycle-level model.

// File: rtl/alc_seq_pkg.sv
package alc_seq_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    // Window phase of the update period
    typedef enum logic [0:0] {
        WIN_SETTLE = 1'b0,
        WIN_DETECT = 1'b1
    } win_state_e;

    // Step outcome taken at the end of a detect window
    typedef enum logic [1:0] {
        STEP_HOLD  = 2'd0,
        STEP_RAISE = 2'd1,  // gain up: attenuation code down
        STEP_CUT   = 2'd2   // gain down: attenuation code up
    } step_e;
endpackage

// File: rtl/alc_window_timer.sv
module alc_window_timer
    import alc_seq_pkg::*;
#(
    parameter int SETTLE_CYC = 384,
    parameter int DETECT_CYC = 1152
) (
    input  logic       clk,
    input  logic       rst_n,
    output win_state_e state_q,
    output logic       settle_last,
    output logic       detect_last
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int LONGEST = (SETTLE_CYC > DETECT_CYC) ? SETTLE_CYC : DETECT_CYC;
    localparam int CNT_W   = $clog2(LONGEST + 1);
    localparam logic [CNT_W-1:0] SETTLE_END = CNT_W'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] DETECT_END = CNT_W'(DETECT_CYC - 1);

    win_state_e       state_d;
    logic [CNT_W-1:0] cnt_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WIN_SETTLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WIN_SETTLE: if (cnt_q == SETTLE_END) state_d = WIN_DETECT;
            WIN_DETECT: if (cnt_q == DETECT_END) state_d = WIN_SETTLE;
            default:    state_d = WIN_SETTLE;
        endcase
    end

    // Cycle counter within the current window
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state_d != state_q) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // Outputs
    always_comb begin
        settle_last = 1'b0;
        detect_last = 1'b0;
        unique case (state_q)
            WIN_SETTLE: settle_last = (cnt_q == SETTLE_END);
            WIN_DETECT: detect_last = (cnt_q == DETECT_END);
            default: ;
        endcase
    end
endmodule

// File: rtl/alc_peak_capture.sv
module alc_peak_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic sample,
    input  logic peak_ge_low,
    input  logic peak_gt_high,
    output logic lo_seen,
    output logic hi_seen,
    output logic lo_any,
    output logic hi_any
);
    timeunit 1ns;
    timeprecision 1ps;

    // Sticky flags, cleared right before a detect window opens
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_seen <= 1'b0;
            hi_seen <= 1'b0;
        end else if (clear) begin
            lo_seen <= 1'b0;
            hi_seen <= 1'b0;
        end else if (sample) begin
            lo_seen <= lo_seen | peak_ge_low;
            hi_seen <= hi_seen | peak_gt_high;
        end
    end

    // Include the current cycle so the last detect cycle counts too
    always_comb begin
        lo_any = lo_seen | (sample & peak_ge_low);
        hi_any = hi_seen | (sample & peak_gt_high);
    end
endmodule

// File: rtl/alc_step_decider.sv
module alc_step_decider
    import alc_seq_pkg::*;
#(
    parameter int GAIN_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic              lo_any,
    input  logic              hi_any,
    output logic [GAIN_W-1:0] code_q
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [GAIN_W-1:0] CODE_MAX = '1;
    localparam logic [GAIN_W-1:0] CODE_MIN = '0;

    step_e             step;
    logic [GAIN_W-1:0] code_d;

    // Three-way decision between the two thresholds
    always_comb begin
        if (hi_any) begin
            step = STEP_CUT;
        end else if (!lo_any) begin
            step = STEP_RAISE;
        end else begin
            step = STEP_HOLD;
        end
    end

    // Saturating next code
    always_comb begin
        code_d = code_q;
        unique case (step)
            STEP_CUT:   if (code_q != CODE_MAX) code_d = code_q + GAIN_W'(1);
            STEP_RAISE: if (code_q != CODE_MIN) code_d = code_q - GAIN_W'(1);
            STEP_HOLD:  code_d = code_q;
            default:    code_d = code_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= CODE_MAX;
        end else if (commit) begin
            code_q <= code_d;
        end
    end
endmodule

// File: rtl/alc_level_seq.sv
module alc_level_seq
    import alc_seq_pkg::*;
#(
    parameter int GAIN_W     = 5,
    parameter int SETTLE_CYC = 384,
    parameter int DETECT_CYC = 1152
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              peak_ge_low,
    input  logic              peak_gt_high,
    output logic [GAIN_W-1:0] atten_code,
    output logic              win_detect
);
    timeunit 1ns;
    timeprecision 1ps;

    win_state_e win_state;
    logic       settle_last;
    logic       detect_last;
    logic       lo_seen;
    logic       hi_seen;
    logic       lo_any;
    logic       hi_any;

    alc_window_timer #(
        .SETTLE_CYC (SETTLE_CYC),
        .DETECT_CYC (DETECT_CYC)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .state_q     (win_state),
        .settle_last (settle_last),
        .detect_last (detect_last)
    );

    alc_peak_capture u_capture (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear        (settle_last),
        .sample       (win_state == WIN_DETECT),
        .peak_ge_low  (peak_ge_low),
        .peak_gt_high (peak_gt_high),
        .lo_seen      (lo_seen),
        .hi_seen      (hi_seen),
        .lo_any       (lo_any),
        .hi_any       (hi_any)
    );

    alc_step_decider #(
        .GAIN_W (GAIN_W)
    ) u_decider (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (detect_last),
        .lo_any (lo_any),
        .hi_any (hi_any),
        .code_q (atten_code)
    );

    assign win_detect = (win_state == WIN_DETECT);
endmodule

// File: rtl/alc_level_seq_chk.sv
module alc_level_seq_chk #(
    parameter int GAIN_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              win_detect,
    input logic              detect_last,
    input logic              lo_seen,
    input logic              hi_seen,
    input logic              peak_ge_low,
    input logic              peak_gt_high,
    input logic [GAIN_W-1:0] atten_code
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [GAIN_W-1:0] CODE_MAX = '1;

    logic lo_now;
    logic hi_now;
    assign lo_now = lo_seen | peak_ge_low;
    assign hi_now = hi_seen | peak_gt_high;

    // R3
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !detect_last |=> $stable(atten_code));

    // R6
    cut_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (detect_last && hi_now && atten_code != CODE_MAX)
        |=> atten_code == $past(atten_code) + GAIN_W'(1));

    // R4
    raise_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (detect_last && !hi_now && !lo_now && atten_code != '0)
        |=> atten_code == $past(atten_code) - GAIN_W'(1));

    // R5
    band_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (detect_last && lo_now && !hi_now) |=> $stable(atten_code));

    // R8
    top_rail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (detect_last && hi_now && atten_code == CODE_MAX) |=> atten_code == CODE_MAX);

    // R8
    bottom_rail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (detect_last && !hi_now && !lo_now && atten_code == '0) |=> atten_code == '0);

    // R7
    fresh_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_detect) |-> (!lo_seen && !hi_seen));
endmodule

bind alc_level_seq alc_level_seq_chk #(.GAIN_W(GAIN_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .win_detect   (win_detect),
    .detect_last  (detect_last),
    .lo_seen      (lo_seen),
    .hi_seen      (hi_seen),
    .peak_ge_low  (peak_ge_low),
    .peak_gt_high (peak_gt_high),
    .atten_code   (atten_code)
);

// File: tb/alc_level_seq_bench.sv
module alc_level_seq_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int S = 5;
    localparam int D = 11;
    localparam int P = S + D;
    localparam int WD_CYCLES = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       peak_ge_low = 1'b0;
    logic       peak_gt_high = 1'b0;
    logic [4:0] atten_code;
    logic       win_detect;

    int  checks = 0;
    int  errors = 0;
    bit  mon_on = 1'b0;
    bit  done = 1'b0;

    // reference model state
    int         pc = 0;
    logic [4:0] mcode = 5'd31;
    bit         acc_lo = 1'b0;
    bit         acc_hi = 1'b0;

    always #5 clk = ~clk;

    alc_level_seq #(.GAIN_W(5), .SETTLE_CYC(S), .DETECT_CYC(D)) u_alc_level_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .peak_ge_low  (peak_ge_low),
        .peak_gt_high (peak_gt_high),
        .atten_code   (atten_code),
        .win_detect   (win_detect)
    );

    function automatic logic [4:0] next_code(input logic [4:0] c, input bit lo, input bit hi);
        if (hi) return (c == 5'd31) ? c : c + 5'd1;
        if (!lo) return (c == 5'd0) ? c : c - 5'd1;
        return c;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // cycle model built from the requirements
    always @(posedge clk) begin
        if (!rst_n) begin
            pc = 0; mcode = 5'd31; acc_lo = 0; acc_hi = 0;
        end else begin
            if (pc >= S) begin
                acc_lo = acc_lo | peak_ge_low;
                acc_hi = acc_hi | peak_gt_high;
                if (pc == P - 1) mcode = next_code(mcode, acc_lo, acc_hi);
            end
            if (pc == S - 1) begin acc_lo = 0; acc_hi = 0; end
            pc = (pc == P - 1) ? 0 : pc + 1;
        end
    end

    always @(negedge clk) begin
        if (mon_on) begin
            chk("R2 phase vs model", int'(win_detect), int'(pc >= S));
            chk("R3 code vs model", int'(atten_code), int'(mcode));
        end
    end

    function automatic bit pick(input int mode, input int i);
        case (mode)
            1: return 1'b1;
            2: return (i == 0);
            3: return (i == D - 1);
            default: return 1'b0;
        endcase
    endfunction

    // modes: 0 never, 1 every detect cycle, 2 first detect cycle only, 3 last only
    task automatic run_win(input int lo_mode, input int hi_mode);
        while (pc != S) @(negedge clk);
        for (int i = 0; i < D; i++) begin
            peak_ge_low  = pick(lo_mode, i);
            peak_gt_high = pick(hi_mode, i);
            @(negedge clk);
        end
        peak_ge_low = 1'b0;
        peak_gt_high = 1'b0;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n;
        int seed;
        seed = $urandom(7536);
        repeat (3) @(negedge clk);
        chk("R1 code in reset", int'(atten_code), 31);
        chk("R1 phase in reset", int'(win_detect), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 code after reset", int'(atten_code), 31);
        chk("R1 phase after reset", int'(win_detect), 0);
        mon_on = 1'b1;

        // R2 window lengths, code held in band meanwhile
        peak_ge_low = 1'b1;
        while (!win_detect) @(negedge clk);
        n = 0;
        while (win_detect) begin n++; @(negedge clk); end
        chk("R2 detect length", n, D);
        n = 0;
        while (!win_detect) begin n++; @(negedge clk); end
        chk("R2 settle length", n, S);
        chk("R5 band hold at 31", int'(atten_code), 31);
        peak_ge_low = 1'b0;

        // R4 / R10 full travel
        for (int k = 1; k <= 31; k++) begin
            run_win(0, 0);
            if (k == 1)  chk("R4 quiet window lowers code", int'(atten_code), 30);
            if (k == 30) chk("R10 one window short of zero", int'(atten_code), 1);
            if (k == 31) chk("R10 zero after 31 windows", int'(atten_code), 0);
        end
        run_win(0, 0);
        chk("R8 bottom rail", int'(atten_code), 0);

        // R6 / R9
        run_win(1, 1);
        chk("R6 high overrides low", int'(atten_code), 1);
        run_win(0, 3);
        chk("R9 high on last detect cycle", int'(atten_code), 2);
        run_win(0, 2);
        chk("R9 high on first detect cycle", int'(atten_code), 3);

        // R5 / R9 low flag alone
        run_win(1, 0);
        chk("R5 low all window holds", int'(atten_code), 3);
        run_win(3, 0);
        chk("R9 low on last cycle holds", int'(atten_code), 3);
        run_win(2, 0);
        chk("R9 low on first cycle holds", int'(atten_code), 3);

        // R7 settle noise ignored
        while (pc != 0) @(negedge clk);
        for (int i = 0; i < S; i++) begin
            peak_gt_high = 1'b1;
            peak_ge_low = 1'b0;
            @(negedge clk);
        end
        peak_gt_high = 1'b0;
        run_win(1, 0);
        chk("R7 high during settle ignored", int'(atten_code), 3);
        run_win(1, 3);
        chk("R6 late high cuts", int'(atten_code), 4);
        run_win(1, 0);
        chk("R7 sticky cleared next window", int'(atten_code), 4);

        // R8 top rail
        for (int k = 0; k < 27; k++) run_win(0, 1);
        chk("R8 reached top", int'(atten_code), 31);
        run_win(1, 1);
        chk("R8 top rail", int'(atten_code), 31);

        // random windows against the model
        for (int w = 0; w < 80; w++) begin
            int mode;
            mode = int'($urandom % 4);
            while (pc != 0) @(negedge clk);
            for (int i = 0; i < P; i++) begin
                case (mode)
                    0: begin peak_ge_low = 1'b0; peak_gt_high = (i < S) ? 1'($urandom % 2) : 1'b0; end
                    1: begin peak_ge_low = (($urandom % 4) == 0); peak_gt_high = (i < S) ? 1'($urandom % 2) : 1'b0; end
                    2: begin peak_ge_low = 1'($urandom % 2); peak_gt_high = (($urandom % 16) == 0); end
                    default: begin peak_ge_low = 1'($urandom % 2); peak_gt_high = 1'($urandom % 2); end
                endcase
                @(negedge clk);
            end
        end
        peak_ge_low = 1'b0;
        peak_gt_high = 1'b0;
        @(negedge clk);
        chk("R3 final code vs model", int'(atten_code), int'(mcode));

        done = 1'b1;
        mon_on = 1'b0;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule